// File: doc/BRIEF.md
# Round-Robin AXI-Lite Arbiter

This block lets several AXI-Lite masters share one AXI-Lite slave. Exactly one master owns the slave at a time. The owner's channels pass straight through to the slave. Every other master sees its ready and response-valid outputs held low until it becomes the owner.

Ownership lasts for one whole transaction, including however long the slave takes to answer. After the write response or read response handshake, the arbiter spends one cycle deciding who goes next. If the owner is already asking again in that cycle, it keeps the slave, so a master streaming back-to-back accesses finishes its run before anyone else is served. If the owner is idle in that cycle, the search starts at the master after the owner and wraps around, so masters that pause between accesses are served in turn.

Top module: `lite_rr_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, no slave-side valid is high and no master sees a ready or a response valid, even if a master is requesting.
- R2: In any cycle, at most one master sees any of AWREADY, WREADY, ARREADY, BVALID or RVALID high.
- R3: Once a master is granted, no other master is served until the granted transaction's B or R handshake completes, however many cycles the slave waits before responding.
- R4: The slave's response code and read data are delivered to the owner only. The response code is 2 bits; the bench slave answers 2'b10 for addresses whose two low bits are 2'b11 and 2'b00 otherwise.
- R5: A transaction is treated as a write when the chosen master has AWVALID or WVALID high at the grant decision, and as a read otherwise. During a write the AR channel stays closed (ARREADY low, slave ARVALID low), and during a read the AW and W channels stay closed.
- R6: Each grant carries exactly one transaction. After an address or data beat has been accepted, that channel is not forwarded again until the response completes.
- R7: When the owner is idle, the next master is searched for starting at the index after the last owner, wrapping around. After reset, master 0 has the highest priority.
- R8: The arbitration decision is made in the cycle after a response handshake. If the owner has any valid high in that cycle, it keeps the grant.
- R9: Masters that leave one idle cycle between accesses are served in strict rotation: 0, 1, 2, 0, and so on.
- R10: Address, write data and write strobes reach the slave unchanged from the owner. Read data reaches the owner unchanged from the slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_awvalid | input | N_MST | Write address valid, one bit per master |
| m_awready | output | N_MST | Write address ready, one bit per master |
| m_awaddr | input | N_MST*ADDR_W | Write addresses, master i in slice i |
| m_wvalid | input | N_MST | Write data valid per master |
| m_wready | output | N_MST | Write data ready per master |
| m_wdata | input | N_MST*DATA_W | Write data per master |
| m_wstrb | input | N_MST*STRB_W | Write strobes per master |
| m_bvalid | output | N_MST | Write response valid per master |
| m_bready | input | N_MST | Write response ready per master |
| m_bresp | output | N_MST*2 | Write response code per master |
| m_arvalid | input | N_MST | Read address valid per master |
| m_arready | output | N_MST | Read address ready per master |
| m_araddr | input | N_MST*ADDR_W | Read addresses per master |
| m_rvalid | output | N_MST | Read data valid per master |
| m_rready | input | N_MST | Read data ready per master |
| m_rdata | output | N_MST*DATA_W | Read data per master |
| m_rresp | output | N_MST*2 | Read response code per master |
| s_awvalid | output | 1 | Slave write address valid |
| s_awready | input | 1 | Slave write address ready |
| s_awaddr | output | ADDR_W | Slave write address |
| s_wvalid | output | 1 | Slave write data valid |
| s_wready | input | 1 | Slave write data ready |
| s_wdata | output | DATA_W | Slave write data |
| s_wstrb | output | STRB_W | Slave write strobes |
| s_bvalid | input | 1 | Slave write response valid |
| s_bready | output | 1 | Slave write response ready |
| s_bresp | input | 2 | Slave write response code |
| s_arvalid | output | 1 | Slave read address valid |
| s_arready | input | 1 | Slave read address ready |
| s_araddr | output | ADDR_W | Slave read address |
| s_rvalid | input | 1 | Slave read data valid |
| s_rready | output | 1 | Slave read data ready |
| s_rdata | input | DATA_W | Slave read data |
| s_rresp | input | 2 | Slave read response code |

## Verification
The arbitration cycle that follows a response handshake is the point where two functions meet. In that one cycle the arbiter must choose between letting the owner keep the slave and rotating to a waiting master.

The bench provokes both outcomes with all three masters requesting at once. In one run each master issues its next access in the cycle right after its response; in the other, each master waits one idle cycle first. The slave records the order in which accesses arrive, and that order is compared with a precomputed sequence. A run in which a master raises a read and a write together shows that the two kinds are kept apart and that the pending read keeps the grant.

// File: rtl/lra_pkg.sv
package lra_pkg;

    typedef enum logic {
        XK_READ  = 1'b0,
        XK_WRITE = 1'b1
    } xkind_e;

    // Channel beats already accepted within the current grant
    typedef struct packed {
        logic aw;
        logic w;
        logic ar;
    } taken_t;

    function automatic int unsigned wrap_idx(int unsigned base, int unsigned step, int unsigned n);
        return (base + step) % n;
    endfunction

endpackage

// File: rtl/lra_rr_pick.sv
module lra_rr_pick
    import lra_pkg::*;
#(
    parameter int N  = 3,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] pick
);

    int unsigned idx_v;

    // Search starts one past the last owner and wraps; the last owner is tried last
    always_comb begin
        found = 1'b0;
        pick  = '0;
        idx_v = 0;
        for (int k = 1; k <= N; k++) begin
            idx_v = wrap_idx(int'(last), k, N);
            if (!found && req[idx_v]) begin
                found = 1'b1;
                pick  = IW'(idx_v);
            end
        end
    end

endmodule

// File: rtl/lra_grant_ctrl.sv
module lra_grant_ctrl
    import lra_pkg::*;
#(
    parameter int N  = 3,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  wr_req,
    input  logic          aw_hs,
    input  logic          w_hs,
    input  logic          ar_hs,
    input  logic          resp_hs,
    output logic [IW-1:0] grant,
    output logic          active,
    output xkind_e        kind,
    output taken_t        taken
);

    logic [IW-1:0] grant_q;
    logic          active_q;
    logic          own_q;
    xkind_e        kind_q;
    taken_t        taken_q;

    logic          rr_found;
    logic [IW-1:0] rr_idx;
    logic          keep;
    logic          nxt_ok;
    logic [IW-1:0] nxt_idx;

    lra_rr_pick #(.N(N), .IW(IW)) u_pick (
        .req   (req),
        .last  (grant_q),
        .found (rr_found),
        .pick  (rr_idx)
    );

    // Owner still asking in the decision cycle keeps the slave
    always_comb begin
        keep    = own_q && req[grant_q];
        nxt_ok  = keep || rr_found;
        nxt_idx = keep ? grant_q : rr_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q  <= IW'(N - 1);
            active_q <= 1'b0;
            own_q    <= 1'b0;
            kind_q   <= XK_READ;
            taken_q  <= '0;
        end else if (!active_q) begin
            if (nxt_ok) begin
                active_q <= 1'b1;
                grant_q  <= nxt_idx;
                own_q    <= 1'b1;
                kind_q   <= wr_req[nxt_idx] ? XK_WRITE : XK_READ;
                taken_q  <= '0;
            end
        end else begin
            if (aw_hs)   taken_q.aw <= 1'b1;
            if (w_hs)    taken_q.w  <= 1'b1;
            if (ar_hs)   taken_q.ar <= 1'b1;
            if (resp_hs) active_q   <= 1'b0;
        end
    end

    assign grant  = grant_q;
    assign active = active_q;
    assign kind   = kind_q;
    assign taken  = taken_q;

endmodule

// File: rtl/lra_route.sv
module lra_route
    import lra_pkg::*;
#(
    parameter int N      = 3,
    parameter int IW     = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int STRB_W = 4
) (
    input  logic [IW-1:0]       grant,
    input  logic                active,
    input  xkind_e              kind,
    input  taken_t              taken,
    input  logic [N-1:0]        m_awvalid,
    output logic [N-1:0]        m_awready,
    input  logic [N*ADDR_W-1:0] m_awaddr,
    input  logic [N-1:0]        m_wvalid,
    output logic [N-1:0]        m_wready,
    input  logic [N*DATA_W-1:0] m_wdata,
    input  logic [N*STRB_W-1:0] m_wstrb,
    output logic [N-1:0]        m_bvalid,
    input  logic [N-1:0]        m_bready,
    output logic [N*2-1:0]      m_bresp,
    input  logic [N-1:0]        m_arvalid,
    output logic [N-1:0]        m_arready,
    input  logic [N*ADDR_W-1:0] m_araddr,
    output logic [N-1:0]        m_rvalid,
    input  logic [N-1:0]        m_rready,
    output logic [N*DATA_W-1:0] m_rdata,
    output logic [N*2-1:0]      m_rresp,
    output logic                s_awvalid,
    input  logic                s_awready,
    output logic [ADDR_W-1:0]   s_awaddr,
    output logic                s_wvalid,
    input  logic                s_wready,
    output logic [DATA_W-1:0]   s_wdata,
    output logic [STRB_W-1:0]   s_wstrb,
    input  logic                s_bvalid,
    output logic                s_bready,
    input  logic [1:0]          s_bresp,
    output logic                s_arvalid,
    input  logic                s_arready,
    output logic [ADDR_W-1:0]   s_araddr,
    input  logic                s_rvalid,
    output logic                s_rready,
    input  logic [DATA_W-1:0]   s_rdata,
    input  logic [1:0]          s_rresp
);

    logic       wr_ph;
    logic       rd_ph;
    logic [N-1:0] sel;

    assign wr_ph = active && (kind == XK_WRITE);
    assign rd_ph = active && (kind == XK_READ);

    // Return path towards each master
    for (genvar gi = 0; gi < N; gi++) begin : g_mst
        assign sel[gi]                    = (grant == IW'(gi));
        assign m_awready[gi]              = sel[gi] && wr_ph && !taken.aw && s_awready;
        assign m_wready[gi]               = sel[gi] && wr_ph && !taken.w  && s_wready;
        assign m_arready[gi]              = sel[gi] && rd_ph && !taken.ar && s_arready;
        assign m_bvalid[gi]               = sel[gi] && wr_ph && s_bvalid;
        assign m_rvalid[gi]               = sel[gi] && rd_ph && s_rvalid;
        assign m_bresp[gi*2 +: 2]         = s_bresp;
        assign m_rresp[gi*2 +: 2]         = s_rresp;
        assign m_rdata[gi*DATA_W +: DATA_W] = s_rdata;
    end

    // Forward path from the owner
    always_comb begin
        s_awaddr  = m_awaddr[int'(grant)*ADDR_W +: ADDR_W];
        s_wdata   = m_wdata[int'(grant)*DATA_W +: DATA_W];
        s_wstrb   = m_wstrb[int'(grant)*STRB_W +: STRB_W];
        s_araddr  = m_araddr[int'(grant)*ADDR_W +: ADDR_W];
        s_awvalid = wr_ph && !taken.aw && m_awvalid[grant];
        s_wvalid  = wr_ph && !taken.w  && m_wvalid[grant];
        s_bready  = wr_ph && m_bready[grant];
        s_arvalid = rd_ph && !taken.ar && m_arvalid[grant];
        s_rready  = rd_ph && m_rready[grant];
    end

endmodule

// File: rtl/lite_rr_arbiter.sv
module lite_rr_arbiter
    import lra_pkg::*;
#(
    parameter int N_MST  = 3,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int STRB_W = DATA_W / 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_MST-1:0]        m_awvalid,
    output logic [N_MST-1:0]        m_awready,
    input  logic [N_MST*ADDR_W-1:0] m_awaddr,
    input  logic [N_MST-1:0]        m_wvalid,
    output logic [N_MST-1:0]        m_wready,
    input  logic [N_MST*DATA_W-1:0] m_wdata,
    input  logic [N_MST*STRB_W-1:0] m_wstrb,
    output logic [N_MST-1:0]        m_bvalid,
    input  logic [N_MST-1:0]        m_bready,
    output logic [N_MST*2-1:0]      m_bresp,
    input  logic [N_MST-1:0]        m_arvalid,
    output logic [N_MST-1:0]        m_arready,
    input  logic [N_MST*ADDR_W-1:0] m_araddr,
    output logic [N_MST-1:0]        m_rvalid,
    input  logic [N_MST-1:0]        m_rready,
    output logic [N_MST*DATA_W-1:0] m_rdata,
    output logic [N_MST*2-1:0]      m_rresp,
    output logic                    s_awvalid,
    input  logic                    s_awready,
    output logic [ADDR_W-1:0]       s_awaddr,
    output logic                    s_wvalid,
    input  logic                    s_wready,
    output logic [DATA_W-1:0]       s_wdata,
    output logic [STRB_W-1:0]       s_wstrb,
    input  logic                    s_bvalid,
    output logic                    s_bready,
    input  logic [1:0]              s_bresp,
    output logic                    s_arvalid,
    input  logic                    s_arready,
    output logic [ADDR_W-1:0]       s_araddr,
    input  logic                    s_rvalid,
    output logic                    s_rready,
    input  logic [DATA_W-1:0]       s_rdata,
    input  logic [1:0]              s_rresp
);

    localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1;

    logic [N_MST-1:0] req;
    logic [N_MST-1:0] wr_req;
    logic [IW-1:0]    grant;
    logic             active;
    xkind_e           kind;
    taken_t           taken;
    logic             aw_hs;
    logic             w_hs;
    logic             ar_hs;
    logic             resp_hs;

    assign req     = m_awvalid | m_wvalid | m_arvalid;
    assign wr_req  = m_awvalid | m_wvalid;
    assign aw_hs   = s_awvalid && s_awready;
    assign w_hs    = s_wvalid && s_wready;
    assign ar_hs   = s_arvalid && s_arready;
    assign resp_hs = (s_bvalid && s_bready) || (s_rvalid && s_rready);

    lra_grant_ctrl #(.N(N_MST), .IW(IW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .wr_req  (wr_req),
        .aw_hs   (aw_hs),
        .w_hs    (w_hs),
        .ar_hs   (ar_hs),
        .resp_hs (resp_hs),
        .grant   (grant),
        .active  (active),
        .kind    (kind),
        .taken   (taken)
    );

    lra_route #(
        .N(N_MST), .IW(IW), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRB_W(STRB_W)
    ) u_route (
        .grant     (grant),
        .active    (active),
        .kind      (kind),
        .taken     (taken),
        .m_awvalid (m_awvalid),
        .m_awready (m_awready),
        .m_awaddr  (m_awaddr),
        .m_wvalid  (m_wvalid),
        .m_wready  (m_wready),
        .m_wdata   (m_wdata),
        .m_wstrb   (m_wstrb),
        .m_bvalid  (m_bvalid),
        .m_bready  (m_bready),
        .m_bresp   (m_bresp),
        .m_arvalid (m_arvalid),
        .m_arready (m_arready),
        .m_araddr  (m_araddr),
        .m_rvalid  (m_rvalid),
        .m_rready  (m_rready),
        .m_rdata   (m_rdata),
        .m_rresp   (m_rresp),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_awaddr  (s_awaddr),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_wdata   (s_wdata),
        .s_wstrb   (s_wstrb),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_bresp   (s_bresp),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_araddr  (s_araddr),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp)
    );

endmodule

// File: rtl/lra_checker.sv
module lra_checker #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  m_awready,
    input logic [N-1:0]  m_wready,
    input logic [N-1:0]  m_arready,
    input logic [N-1:0]  m_bvalid,
    input logic [N-1:0]  m_bready,
    input logic [N-1:0]  m_rvalid,
    input logic [N-1:0]  m_rready,
    input logic          s_awvalid,
    input logic          s_awready,
    input logic          s_wvalid,
    input logic          s_arvalid,
    input logic          s_arready,
    input logic          s_bvalid,
    input logic          s_bready,
    input logic          s_rvalid,
    input logic          s_rready,
    input logic [IW-1:0] grant,
    input logic          active,
    input logic          resp_hs
);

    logic [N-1:0] touched;
    assign touched = m_awready | m_wready | m_arready | m_bvalid | m_rvalid;

    AST_QUIET_AFTER_RST: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (!(s_awvalid || s_wvalid || s_arvalid) && (touched == '0))); // R1
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst) $onehot0(touched)); // R2
    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (rst) (active && !resp_hs) |=> (active && $stable(grant))); // R3
    AST_B_TO_OWNER: assert property (@(posedge clk) disable iff (rst) (s_bvalid && s_bready) |-> ($countones(m_bvalid & m_bready) == 1)); // R4
    AST_R_TO_OWNER: assert property (@(posedge clk) disable iff (rst) (s_rvalid && s_rready) |-> ($countones(m_rvalid & m_rready) == 1)); // R4
    AST_KIND_EXCL: assert property (@(posedge clk) disable iff (rst) !(s_arvalid && (s_awvalid || s_wvalid))); // R5
    AST_ONE_AW: assert property (@(posedge clk) disable iff (rst) (s_awvalid && s_awready) |=> !s_awvalid); // R6
    AST_ONE_AR: assert property (@(posedge clk) disable iff (rst) (s_arvalid && s_arready) |=> !s_arvalid); // R6
    AST_DECIDE_GAP: assert property (@(posedge clk) disable iff (rst) resp_hs |=> !(s_awvalid || s_wvalid || s_arvalid)); // R8

endmodule

bind lite_rr_arbiter lra_checker #(.N(N_MST), .IW(IW)) u_lra_chk (
    .clk       (clk),
    .rst       (rst),
    .m_awready (m_awready),
    .m_wready  (m_wready),
    .m_arready (m_arready),
    .m_bvalid  (m_bvalid),
    .m_bready  (m_bready),
    .m_rvalid  (m_rvalid),
    .m_rready  (m_rready),
    .s_awvalid (s_awvalid),
    .s_awready (s_awready),
    .s_wvalid  (s_wvalid),
    .s_arvalid (s_arvalid),
    .s_arready (s_arready),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .grant     (grant),
    .active    (active),
    .resp_hs   (resp_hs)
);

// File: tb/lite_rr_arbiter_tb.sv
`timescale 1ns/1ps
module lite_rr_arbiter_tb;

    localparam int N  = 3;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [N-1:0]    m_awvalid = '0, m_wvalid = '0, m_arvalid = '0, m_bready = '0, m_rready = '0;
    logic [N*AW-1:0] m_awaddr = '0, m_araddr = '0;
    logic [N*DW-1:0] m_wdata = '0;
    logic [N*SW-1:0] m_wstrb = '0;
    logic [N-1:0]    m_awready, m_wready, m_bvalid, m_arready, m_rvalid;
    logic [N*2-1:0]  m_bresp, m_rresp;
    logic [N*DW-1:0] m_rdata;

    logic          s_awvalid, s_wvalid, s_bready, s_arvalid, s_rready;
    logic [AW-1:0] s_awaddr, s_araddr;
    logic [DW-1:0] s_wdata;
    logic [SW-1:0] s_wstrb;
    logic          s_awready = 1'b0, s_wready = 1'b0, s_arready = 1'b0, s_bvalid = 1'b0, s_rvalid = 1'b0;
    logic [1:0]    s_bresp = 2'b00, s_rresp = 2'b00;
    logic [DW-1:0] s_rdata = '0;

    lite_rr_arbiter #(.N_MST(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp)
    );

    int nchk = 0;
    int nbad = 0;
    int mon_bad = 0;
    int slv_lat = 0;
    bit finished = 0;

    logic [AW-1:0] lg_addr [0:63];
    logic [DW-1:0] lg_data [0:63];
    logic [SW-1:0] lg_strb [0:63];
    logic          lg_wr   [0:63];
    int            lg_n = 0;

    function automatic logic [1:0] exp_resp(logic [AW-1:0] a);
        return (a[1:0] == 2'b11) ? 2'b10 : 2'b00;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Slave model: accepts a write when AW and W are both offered, a read otherwise
    initial begin
        logic [AW-1:0] ra;
        forever begin
            @(negedge clk);
            s_bvalid = 1'b0; s_rvalid = 1'b0;
            s_awready = 1'b1; s_wready = 1'b1; s_arready = 1'b1;
            #3;
            if (s_awvalid && s_wvalid) begin
                if (lg_n < 64) begin
                    lg_addr[lg_n] = s_awaddr; lg_data[lg_n] = s_wdata;
                    lg_strb[lg_n] = s_wstrb; lg_wr[lg_n] = 1'b1; lg_n++;
                end
                ra = s_awaddr;
                @(negedge clk);
                s_awready = 1'b0; s_wready = 1'b0; s_arready = 1'b0;
                repeat (slv_lat) @(negedge clk);
                s_bvalid = 1'b1; s_bresp = exp_resp(ra);
                #3;
                while (!s_bready) begin @(negedge clk); #3; end
            end else if (s_arvalid) begin
                if (lg_n < 64) begin
                    lg_addr[lg_n] = s_araddr; lg_data[lg_n] = '0;
                    lg_strb[lg_n] = '0; lg_wr[lg_n] = 1'b0; lg_n++;
                end
                ra = s_araddr;
                @(negedge clk);
                s_awready = 1'b0; s_wready = 1'b0; s_arready = 1'b0;
                repeat (slv_lat) @(negedge clk);
                s_rvalid = 1'b1; s_rresp = exp_resp(ra); s_rdata = ra ^ 32'h5A5A_0000;
                #3;
                while (!s_rready) begin @(negedge clk); #3; end
            end
        end
    end

    // R2 monitor: never more than one master touched
    initial begin
        forever begin
            @(negedge clk); #3;
            if ($countones(m_awready | m_wready | m_arready | m_bvalid | m_rvalid) > 1) mon_bad++;
        end
    end

    task automatic mst_wr(input int i, input logic [AW-1:0] a, input logic [SW-1:0] st, output logic [1:0] rsp);
        bit aw_ok = 0;
        bit w_ok = 0;
        m_awvalid[i] = 1'b1; m_awaddr[i*AW +: AW] = a;
        m_wvalid[i] = 1'b1;  m_wdata[i*DW +: DW] = a + 32'h0001_0000;
        m_wstrb[i*SW +: SW] = st; m_bready[i] = 1'b1;
        while (!(aw_ok && w_ok)) begin
            #3;
            if (m_awready[i]) aw_ok = 1;
            if (m_wready[i]) w_ok = 1;
            @(negedge clk);
            if (aw_ok) m_awvalid[i] = 1'b0;
            if (w_ok) m_wvalid[i] = 1'b0;
        end
        #3;
        while (!m_bvalid[i]) begin @(negedge clk); #3; end
        rsp = m_bresp[i*2 +: 2];
        @(negedge clk);
        m_bready[i] = 1'b0;
    endtask

    task automatic mst_rd(input int i, input logic [AW-1:0] a, output logic [DW-1:0] d, output logic [1:0] rsp);
        m_arvalid[i] = 1'b1; m_araddr[i*AW +: AW] = a; m_rready[i] = 1'b1;
        #3;
        while (!m_arready[i]) begin @(negedge clk); #3; end
        @(negedge clk);
        m_arvalid[i] = 1'b0;
        #3;
        while (!m_rvalid[i]) begin @(negedge clk); #3; end
        d = m_rdata[i*DW +: DW];
        rsp = m_rresp[i*2 +: 2];
        @(negedge clk);
        m_rready[i] = 1'b0;
    endtask

    task automatic mst_run(input int i, input bit gap);
        for (int k = 0; k < 8; k++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            logic [1:0] r;
            a = AW'(100 * i + (k % 4));
            if (k < 4) begin
                mst_wr(i, a, (k == 1) ? 4'b0101 : 4'hF, r);
                chk(r == exp_resp(a), "R4 bresp to owner", 64'(r), 64'(exp_resp(a)));
            end else begin
                mst_rd(i, a, d, r);
                chk(d == (a ^ 32'h5A5A_0000), "R10 rdata to owner", 64'(d), 64'(a ^ 32'h5A5A_0000));
                chk(r == exp_resp(a), "R4 rresp to owner", 64'(r), 64'(exp_resp(a)));
            end
            if (gap) @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        m_awvalid = '0; m_wvalid = '0; m_arvalid = '0; m_bready = '0; m_rready = '0;
        repeat (2) @(negedge clk);
        lg_n = 0;
        rst = 1'b0;
    endtask

    task automatic chk_entry(input int j, input bit wr, input logic [AW-1:0] a, input string tag);
        chk(lg_wr[j] == wr, tag, 64'(lg_wr[j]), 64'(wr));
        chk(lg_addr[j] == a, tag, 64'(lg_addr[j]), 64'(a));
    endtask

    // R1: requests during reset are not forwarded
    task automatic t_reset_quiet();
        rst = 1'b1;
        @(negedge clk);
        m_awvalid[0] = 1'b1; m_wvalid[0] = 1'b1; m_arvalid[1] = 1'b1;
        #3;
        chk(!s_awvalid && !s_wvalid && !s_arvalid, "R1 slave valids in reset", 64'({s_awvalid, s_wvalid, s_arvalid}), 0);
        chk((m_awready | m_wready | m_arready | m_bvalid | m_rvalid) == '0, "R1 master side in reset",
            64'(m_awready | m_wready | m_arready), 0);
        @(negedge clk);
        m_awvalid = '0; m_wvalid = '0; m_arvalid = '0;
        rst = 1'b0;
        #3;
        chk(!s_awvalid && !s_wvalid && !s_arvalid, "R1 first cycle after reset", 64'({s_awvalid, s_wvalid, s_arvalid}), 0);
        @(negedge clk);
        lg_n = 0;
    endtask

    // R7: priority after reset and wrap-around past the last owner
    task automatic t_rotation();
        logic [1:0] r1, r2;
        do_reset();
        slv_lat = 1;
        fork
            mst_wr(1, 32'h10, 4'hF, r1);
            mst_wr(2, 32'h20, 4'hF, r2);
        join
        repeat (2) @(negedge clk);
        fork
            mst_wr(0, 32'h30, 4'hF, r1);
            mst_wr(1, 32'h34, 4'hF, r2);
        join
        chk(lg_n == 4, "R7 access count", 64'(lg_n), 4);
        chk_entry(0, 1, 32'h10, "R7 first after reset");
        chk_entry(1, 1, 32'h20, "R7 second");
        chk_entry(2, 1, 32'h30, "R7 wrap to master 0");
        chk_entry(3, 1, 32'h34, "R7 then master 1");
    endtask

    // R5 R6 R8: write and read raised together, plus a competing master
    task automatic t_kind_split();
        logic [1:0] r;
        logic [DW-1:0] d;
        bit ar_seen;
        do_reset();
        slv_lat = 2;
        ar_seen = 0;
        m_arvalid[0] = 1'b1; m_araddr[0*AW +: AW] = 32'h44;
        fork
            begin
                fork
                    mst_wr(0, 32'h40, 4'hF, r);
                    begin
                        repeat (5) begin #3; if (m_arready[0] || s_arvalid) ar_seen = 1; @(negedge clk); end
                    end
                join
                mst_rd(0, 32'h44, d, r);
            end
            begin
                mst_wr(1, 32'h80, 4'hF, r);
            end
        join
        chk(!ar_seen, "R5 read channel closed during write", 64'(ar_seen), 0);
        chk(lg_n == 3, "R6 one transaction per grant", 64'(lg_n), 3);
        chk_entry(0, 1, 32'h40, "R5 write chosen first");
        chk_entry(1, 0, 32'h44, "R8 owner keeps grant for read");
        chk_entry(2, 1, 32'h80, "R3 other master after response");
    endtask

    // R3 R8 R10: back-to-back requesters with slow responses
    task automatic t_back_to_back();
        do_reset();
        slv_lat = 3;
        fork
            mst_run(0, 0);
            mst_run(1, 0);
            mst_run(2, 0);
        join
        chk(lg_n == 24, "R3 access count", 64'(lg_n), 24);
        for (int i = 0; i < N; i++) begin
            for (int k = 0; k < 8; k++) begin
                chk_entry(i * 8 + k, k < 4, AW'(100 * i + (k % 4)), "R8 back-to-back order");
            end
        end
        chk(lg_data[9] == 32'h0001_0065, "R10 write data passthrough", 64'(lg_data[9]), 64'h1_0065);
        chk(lg_strb[9] == 4'b0101, "R10 strobe passthrough", 64'(lg_strb[9]), 64'b0101);
        chk(lg_strb[8] == 4'hF, "R10 full strobe", 64'(lg_strb[8]), 64'hF);
    endtask

    // R9: one idle cycle between accesses gives strict rotation
    task automatic t_interleave();
        do_reset();
        slv_lat = 0;
        fork
            mst_run(0, 1);
            mst_run(1, 1);
            mst_run(2, 1);
        join
        chk(lg_n == 24, "R9 access count", 64'(lg_n), 24);
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < N; i++) begin
                chk_entry(k * 3 + i, k < 4, AW'(100 * i + (k % 4)), "R9 interleaved order");
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_quiet();
        t_rotation();
        t_kind_split();
        t_back_to_back();
        t_interleave();
        chk(mon_bad == 0, "R2 single master touched", 64'(mon_bad), 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog R3 actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule